// File: doc/BRIEF.md
# Processor-Local Countdown Interrupt Timer

This block is a per-core timer. Software writes a starting value and the timer counts it down. The countdown advances on ticks made by dividing the core clock by a power of two. When the count runs out, the block sends a single-cycle request, together with an 8-bit vector, to the core's local interrupt prioritizer. The timer has two modes. In one-shot mode it fires once and then stays at zero. In periodic mode it reloads itself and fires again after every full period.

Software reaches the block through four 32-bit registers, selected by a 2-bit index:

- index 0 is the control entry (mode, mask and vector);
- index 1 is the starting value;
- index 2 is the running count, which is read-only;
- index 3 is the clock-divide selector.

Reads are combinational. A write takes effect at the clock edge on which it is presented.

Top module: `irq_countdown_timer`

## Requirements
- R1: The divide selector at index 3 stores only write-data bits 3, 1 and 0. A read of index 3 returns those bits in place and zero in every other bit.
- R2: The divide code is {bit3, bit1, bit0}. The tick period is 2^((code+1) mod 8) clocks, so code 7 ticks every clock and code 0 every 2 clocks. The first tick after a start comes one full tick period after the start edge.
- R3: In the control entry at index 0, bit 17 selects periodic mode, bit 16 masks the timer, and bits 7:0 hold the vector. All other bits read as zero. On every request pulse, `irqVector` carries the vector that was programmed when the timer expired.
- R4: In one-shot mode, starting from N, the count falls by one per tick and then holds at zero. Exactly one pulse is issued, on tick N+1. No further pulse follows until index 1 is written again.
- R5: In periodic mode, the count goes from N down to 0 and reloads to N on tick N+1. A pulse is issued every N+1 ticks.
- R6: A write to index 1 loads the count and restarts the tick divider from that edge. If the write lands on an edge where the timer would expire, the write wins and no pulse is issued.
- R7: While bit 16 is set, no pulse is issued, but counting and reloading continue. A one-shot expiry that occurs while masked is lost. After unmasking, a periodic timer pulses again at its next expiry.
- R8: After reset, index 0 reads 0x0001_0000 (masked), indices 1, 2 and 3 read zero, and no pulse is issued.
- R9: A write to index 2 has no effect on the count.
- R10: `irqPulse` is a single-cycle pulse per expiry, registered on the expiry edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register index |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqPulse | output | 1 | Expiry request, one cycle per expiry |
| irqVector | output | 8 | Vector accompanying the request |

## Verification
A software reload and a count expiry can fall on the same clock edge. The bench forces this by running a one-shot timer to the cycle just before its expiry and then presenting a write to index 1, so that the write lands on the expiry edge. It then checks that no pulse appears, that the count reads the new value, and that the pulse occurs one full period later. The unmask write is also placed so that it lands at the same time as a periodic expiry window. The pulse timeline after it is judged against the rule that the mask is sampled as it was before the write edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int CNT_W   = 32;
  localparam int VEC_W   = 8;
  localparam int SHIFT_W = 3;
  localparam int PRE_W   = (1 << SHIFT_W) - 1;

  localparam logic [1:0] ADDR_ENTRY = 2'd0;
  localparam logic [1:0] ADDR_INIT  = 2'd1;
  localparam logic [1:0] ADDR_CUR   = 2'd2;
  localparam logic [1:0] ADDR_DIV   = 2'd3;

  localparam int BIT_PERIODIC = 17;
  localparam int BIT_MASK     = 16;

  typedef struct packed {
    logic               loadInit;
    logic               periodic;
    logic               masked;
    logic [SHIFT_W-1:0] shift;
  } ctrlStrobes_t;
endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [1:0]           regAddr,
  input  logic [CNT_W-1:0]     regWrData,
  input  logic [CNT_W-1:0]     curCount,
  output logic [CNT_W-1:0]     regRdData,
  output ctrlStrobes_t         strb,
  output logic [CNT_W-1:0]     loadVal,
  output logic [CNT_W-1:0]     reloadVal,
  output logic [VEC_W-1:0]     vecVal
);
  logic               modePeriodic;
  logic               modeMask;
  logic [VEC_W-1:0]   vecReg;
  logic [CNT_W-1:0]   initReg;
  logic [SHIFT_W-1:0] divCode;

  logic wrEntry, wrInit, wrDiv;
  assign wrEntry = regWr && (regAddr == ADDR_ENTRY);
  assign wrInit  = regWr && (regAddr == ADDR_INIT);
  assign wrDiv   = regWr && (regAddr == ADDR_DIV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modePeriodic <= 1'b0;
      modeMask     <= 1'b1;
      vecReg       <= '0;
      initReg      <= '0;
      divCode      <= '0;
    end else begin
      if (wrEntry) begin
        modePeriodic <= regWrData[BIT_PERIODIC];
        modeMask     <= regWrData[BIT_MASK];
        vecReg       <= regWrData[VEC_W-1:0];
      end
      if (wrInit) initReg <= regWrData;
      if (wrDiv)  divCode <= {regWrData[3], regWrData[1], regWrData[0]};
    end
  end

  always_comb begin
    strb.loadInit = wrInit;
    strb.periodic = modePeriodic;
    strb.masked   = modeMask;
    strb.shift    = divCode + SHIFT_W'(1);
  end

  assign loadVal   = regWrData;
  assign reloadVal = initReg;
  assign vecVal    = vecReg;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_ENTRY: begin
        regRdData[BIT_PERIODIC] = modePeriodic;
        regRdData[BIT_MASK]     = modeMask;
        regRdData[VEC_W-1:0]    = vecReg;
      end
      ADDR_INIT: regRdData = initReg;
      ADDR_CUR:  regRdData = curCount;
      ADDR_DIV:  regRdData = {{(CNT_W-4){1'b0}}, divCode[2], 1'b0, divCode[1], divCode[0]};
      default:   regRdData = '0;
    endcase
  end

  AST_SHIFT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrDiv |=> strb.shift == SHIFT_W'({$past(regWrData[3]), $past(regWrData[1]), $past(regWrData[0])} + 3'd1)); // R2
endmodule

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [CNT_W-1:0]   loadVal,
  input  logic [CNT_W-1:0]   reloadVal,
  input  logic [VEC_W-1:0]   vecVal,
  output logic [CNT_W-1:0]   curCount,
  output logic               irqPulse,
  output logic [VEC_W-1:0]   irqVector
);
  logic [PRE_W-1:0] divCnt;
  logic [PRE_W-1:0] tickMask;
  logic             tick;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  assign tickMask = PRE_W'((1 << strb.shift) - 1);
  assign tick     = (divCnt & tickMask) == tickMask;
  assign curCount = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      divCnt    <= '0;
      armed     <= 1'b0;
      irqPulse  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqPulse <= 1'b0;
      if (strb.loadInit) begin
        cnt    <= loadVal;
        divCnt <= '0;
        armed  <= 1'b1;
      end else begin
        divCnt <= divCnt + PRE_W'(1);
        if (tick) begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (strb.periodic) begin
            cnt <= reloadVal;
            if (!strb.masked) begin
              irqPulse  <= 1'b1;
              irqVector <= vecVal;
            end
          end else if (armed) begin
            armed <= 1'b0;
            if (!strb.masked) begin
              irqPulse  <= 1'b1;
              irqVector <= vecVal;
            end
          end
        end
      end
    end
  end

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.masked) |-> !irqPulse); // R7
  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(cnt) == '0)); // R4
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !strb.periodic && !strb.loadInit) |=> (cnt == '0)); // R4
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= reloadVal); // R5
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadInit |=> (cnt == $past(loadVal) && !irqPulse)); // R6
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import cdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irqPulse,
  output logic [7:0]  irqVector
);
  ctrlStrobes_t     strb;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] reloadVal;
  logic [VEC_W-1:0] vecVal;
  logic [CNT_W-1:0] curCount;

  cdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .curCount(curCount), .regRdData(regRdData),
    .strb(strb), .loadVal(loadVal), .reloadVal(reloadVal), .vecVal(vecVal)
  );

  cdt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .reloadVal(reloadVal), .vecVal(vecVal), .curCount(curCount),
    .irqPulse(irqPulse), .irqVector(irqVector)
  );
endmodule

// File: tb/irq_countdown_timer_bench.sv
`timescale 1ns/1ps
module irq_countdown_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd2;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqPulse;
  logic [7:0]  irqVector;

  int checks = 0;
  int errors = 0;
  int t = 0;

  always #2 clk = ~clk;

  irq_countdown_timer u_irq_countdown_timer (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .irqPulse(irqPulse), .irqVector(irqVector)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at t=%0d: actual=%h expected=%h", req, what, t, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1; t++;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    step();
    regWr = 1'b0; regAddr = 2'd2;
  endtask

  task automatic wrInit(input logic [31:0] d);
    wr(2'd1, d);
    t = 0;
  endtask

  function automatic int expCount(int tt, int n, int d, bit per);
    int k = tt / d;
    if (per) return n - (k % (n + 1));
    return (k >= n) ? 0 : n - k;
  endfunction

  function automatic bit expPulse(int tt, int n, int d, bit per, int tu);
    int p = (n + 1) * d;
    if (tt <= 0 || tt <= tu || (tt % p) != 0) return 1'b0;
    return per || (tt == p);
  endfunction

  task automatic checkNow(string req, int n, int d, bit per, int tu, logic [7:0] vec);
    bit ep = expPulse(t, n, d, per, tu);
    regAddr = 2'd2; #0;
    chk(req, "count", regRdData, 32'(expCount(t, n, d, per)));
    chk(req, "pulse", {31'b0, irqPulse}, {31'b0, ep});
    if (ep) chk("R3", "vector", {24'b0, irqVector}, {24'b0, vec});
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired at t=%0d", t);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R8 reset state
    regAddr = 2'd0; #1 chk("R8", "entry", regRdData, 32'h0001_0000);
    regAddr = 2'd1; #1 chk("R8", "init", regRdData, 32'h0);
    regAddr = 2'd2; #1 chk("R8", "current", regRdData, 32'h0);
    regAddr = 2'd3; #1 chk("R8", "divide", regRdData, 32'h0);
    chk("R8", "pulse", {31'b0, irqPulse}, 32'h0);
    regAddr = 2'd2;

    // R1 divide readback keeps bits 3,1,0 only
    wr(2'd3, 32'hFFFF_FFFF);
    regAddr = 2'd3; #0 chk("R1", "divide all-ones", regRdData, 32'h0000_000B);
    wr(2'd3, 32'hFFFF_FFF4);
    regAddr = 2'd3; #0 chk("R1", "divide sparse", regRdData, 32'h0);
    // R3 entry readback drops unused bits
    wr(2'd0, 32'hFFFF_FFFF);
    regAddr = 2'd0; #0 chk("R3", "entry", regRdData, 32'h0003_00FF);

    // R2 R4 R5 sweep over every divide code, small counts, both modes
    for (int code = 0; code < 8; code++) begin
      for (int n = 0; n < 4; n++) begin
        for (int per = 0; per < 2; per++) begin
          int d = 1 << ((code + 1) % 8);
          logic [7:0] vec = 8'(8'h20 + code * 8 + n * 2 + per);
          logic [31:0] dv = 32'hF0 | {28'b0, code[2], 1'b0, code[1], code[0]};
          wr(2'd0, 32'h0001_0000);
          wr(2'd3, dv);
          wrInit(32'(n));
          wr(2'd0, {14'b0, per[0], 1'b0, 8'b0, vec});
          checkNow(per ? "R5" : "R4", n, d, per[0], 1, vec);
          while (t < 2 * (n + 1) * d + 2) begin
            step();
            checkNow(per ? "R5" : "R2", n, d, per[0], 1, vec);
          end
        end
      end
    end

    // R7 periodic, masked then unmasked
    wr(2'd0, 32'h0003_0055);
    wr(2'd3, 32'h0000_000B);
    wrInit(32'd3);
    while (t < 10) begin step(); checkNow("R7", 3, 1, 1'b1, 1000, 8'h55); end
    wr(2'd0, 32'h0002_0055);
    begin
      int tu = t;
      while (t < 30) begin step(); checkNow("R7", 3, 1, 1'b1, tu, 8'h55); end
    end
    // R7 one-shot expiry while masked is lost
    wr(2'd0, 32'h0001_0066);
    wrInit(32'd1);
    while (t < 5) begin step(); checkNow("R7", 1, 1, 1'b0, 1000, 8'h66); end
    wr(2'd0, 32'h0000_0066);
    while (t < 15) begin step(); checkNow("R7", 1, 1, 1'b0, 1000, 8'h66); end

    // R6 reload landing on the expiry edge
    wr(2'd0, 32'h0000_0077);
    wrInit(32'd2);
    step(); step();
    checkNow("R6", 2, 1, 1'b0, 0, 8'h77);
    wrInit(32'd2);
    chk("R6", "collision pulse", {31'b0, irqPulse}, 32'h0);
    checkNow("R6", 2, 1, 1'b0, 0, 8'h77);
    while (t < 8) begin step(); checkNow("R6", 2, 1, 1'b0, 0, 8'h77); end

    // R9 write to current count ignored; R10 single-cycle pulse
    wrInit(32'd50);
    step();
    wr(2'd2, 32'd5);
    checkNow("R9", 50, 1, 1'b0, 0, 8'h77);
    while (t < 53) begin step(); checkNow("R10", 50, 1, 1'b0, 0, 8'h77); end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule